// File: doc/BRIEF.md
# Special Instruction Exception Unit

This block sits beside the execute stage of a 32-bit RISC core and handles the register-format instructions that carry an all-zero major opcode and exist to stop or order execution. Each cycle it may receive one instruction word with a valid strobe, together with the two source operand values already read from the register file. It decides whether the word is a system call, a breakpoint, a memory-ordering barrier or one of six conditional traps. For traps it also evaluates the condition on the operands.

All results are registered. An exception request appears as a one-cycle pulse with a two-bit cause code, one cycle after the instruction is presented. A barrier instruction raises a request to the memory pipeline. That request stays up until the pipeline acknowledges it. A function code that is not one of the nine handled codes raises a one-cycle illegal-function flag and no exception. Exception vectoring, coprocessor state, the register file and the memory pipeline lie outside the block.

Top module: `spec_exc_unit`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `exc_req`, `exc_cause`, `barrier_req` and `illegal_funct` are all zero.
- R2: A valid word with bits [31:26]=0 and function field bits [5:0]=0x0C raises `exc_req` for exactly one cycle, in the cycle after it is presented, with `exc_cause`=2'b01.
- R3: A valid word with opcode 0 and function 0x0D raises `exc_req` for one cycle, in the cycle after it is presented, with `exc_cause`=2'b10.
- R4: A valid word with opcode 0 and function 0x0F raises no exception. It sets `barrier_req` in the next cycle. `barrier_req` then stays high until `sync_ack` is sampled high, and it is low in the cycle after that.
- R5: Function 0x30 traps when rs >= rt and function 0x32 traps when rs < rt, both comparing the operands as signed two's-complement values. A trap gives a one-cycle `exc_req` with `exc_cause`=2'b11.
- R6: Function 0x31 traps when rs >= rt and function 0x33 traps when rs < rt, both comparing the operands as unsigned values. The trap response is the same as in R5.
- R7: Function 0x34 traps when rs equals rt, and function 0x36 traps when they differ. The trap response is the same as in R5.
- R8: A trap instruction whose condition is false raises neither `exc_req` nor `barrier_req`.
- R9: A valid word with opcode 0 and any function code other than the nine above raises `illegal_funct` for one cycle and no exception.
- R10: A word presented with `instr_valid` low, or with a nonzero opcode field, changes no output in the next cycle.
- R11: `exc_cause` reads 2'b00 whenever `exc_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word and operands are valid this cycle |
| instr_word | input | 32 | Instruction word |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| sync_ack | input | 1 | Memory pipeline has drained older loads and stores |
| exc_req | output | 1 | One-cycle exception request |
| exc_cause | output | 2 | 01 system call, 10 breakpoint, 11 trap, 00 idle |
| barrier_req | output | 1 | Load/store ordering request, held until acknowledged |
| illegal_funct | output | 1 | One-cycle flag for an unhandled function code |

## Verification
A fault in a comparator shows up only for some operand pairs. It appears as a missing or spurious trap pulse exactly one cycle after the word is presented. The operand sets therefore straddle the sign boundary and include equal values. A barrier register that clears early or sticks shows up as `barrier_req` dropping before `sync_ack`, or staying high past the cycle after it. The bench checks every cycle of the hold. A decode fault shows up as the wrong cause code or a wrongly set illegal flag in that same single result cycle.

// File: rtl/spec_exc_pkg.sv
package spec_exc_pkg;

  localparam int unsigned INSTR_W = 32;
  localparam int unsigned OPC_W   = 6;
  localparam int unsigned FN_W    = 6;
  localparam int unsigned CAUSE_W = 2;
  localparam int unsigned N_TRAP  = 6;

  localparam logic [FN_W-1:0] FN_SYSCALL = 6'h0C;
  localparam logic [FN_W-1:0] FN_BREAK   = 6'h0D;
  localparam logic [FN_W-1:0] FN_SYNC    = 6'h0F;
  localparam logic [FN_W-1:0] FN_TGE     = 6'h30;
  localparam logic [FN_W-1:0] FN_TGEU    = 6'h31;
  localparam logic [FN_W-1:0] FN_TLT     = 6'h32;
  localparam logic [FN_W-1:0] FN_TLTU    = 6'h33;
  localparam logic [FN_W-1:0] FN_TEQ     = 6'h34;
  localparam logic [FN_W-1:0] FN_TNE     = 6'h36;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_SYS  = 2'b01,
    CAUSE_BRK  = 2'b10,
    CAUSE_TRAP = 2'b11
  } cause_e;

  // trap select bit order
  localparam int unsigned T_GE  = 0;
  localparam int unsigned T_GEU = 1;
  localparam int unsigned T_LT  = 2;
  localparam int unsigned T_LTU = 3;
  localparam int unsigned T_EQ  = 4;
  localparam int unsigned T_NE  = 5;

  typedef struct packed {
    logic              sys;
    logic              brk;
    logic              sync;
    logic [N_TRAP-1:0] trap_sel;
    logic              illegal;
  } dec_t;

  // Unsigned less-than from the borrow of a widened subtraction
  function automatic logic lt_unsigned_from_diff(input logic borrow);
    return borrow;
  endfunction

  // Signed less-than: sign of a if signs differ, else sign of difference
  function automatic logic lt_signed_from_diff(input logic a_msb, input logic b_msb,
                                               input logic diff_msb);
    return (a_msb ^ b_msb) ? a_msb : diff_msb;
  endfunction

endpackage

// File: rtl/spec_decode.sv
module spec_decode
  import spec_exc_pkg::*;
(
  input  logic               valid,
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);

  logic [OPC_W-1:0] opc;
  logic [FN_W-1:0]  fn;
  logic             special;
  logic             unused_fields;

  assign opc           = instr[INSTR_W-1 -: OPC_W];
  assign fn            = instr[FN_W-1:0];
  assign special       = valid && (opc == '0);
  assign unused_fields = ^instr[INSTR_W-OPC_W-1:FN_W];

  always_comb begin
    dec = '0;
    if (special) begin
      unique case (fn)
        FN_SYSCALL: dec.sys             = 1'b1;
        FN_BREAK:   dec.brk             = 1'b1;
        FN_SYNC:    dec.sync            = 1'b1;
        FN_TGE:     dec.trap_sel[T_GE]  = 1'b1;
        FN_TGEU:    dec.trap_sel[T_GEU] = 1'b1;
        FN_TLT:     dec.trap_sel[T_LT]  = 1'b1;
        FN_TLTU:    dec.trap_sel[T_LTU] = 1'b1;
        FN_TEQ:     dec.trap_sel[T_EQ]  = 1'b1;
        FN_TNE:     dec.trap_sel[T_NE]  = 1'b1;
        default:    dec.illegal         = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/trap_compare.sv
module trap_compare
  import spec_exc_pkg::*;
#(
  parameter int unsigned W          = 32,
  parameter bit          SHARED_SUB = 1'b1
) (
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  output logic [N_TRAP-1:0] cond
);

  logic lt_s, lt_u, eq;

  generate
    if (SHARED_SUB) begin : g_shared
      logic [W:0] diff;
      assign diff = {1'b0, a} - {1'b0, b};
      assign lt_u = lt_unsigned_from_diff(diff[W]);
      assign lt_s = lt_signed_from_diff(a[W-1], b[W-1], diff[W-1]);
    end else begin : g_direct
      assign lt_u = (a < b);
      assign lt_s = ($signed(a) < $signed(b));
    end
  endgenerate

  assign eq = (a == b);

  always_comb begin
    cond        = '0;
    cond[T_GE]  = ~lt_s;
    cond[T_GEU] = ~lt_u;
    cond[T_LT]  = lt_s;
    cond[T_LTU] = lt_u;
    cond[T_EQ]  = eq;
    cond[T_NE]  = ~eq;
  end

endmodule

// File: rtl/barrier_ctrl.sv
module barrier_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  output logic req
);

  always_ff @(posedge clk) begin
    if (!rst_n)   req <= 1'b0;
    else if (set) req <= 1'b1;
    else if (ack) req <= 1'b0;
  end

endmodule

// File: rtl/spec_exc_unit.sv
module spec_exc_unit
  import spec_exc_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter bit          SHARED_SUB = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 instr_valid,
  input  logic [INSTR_W-1:0]   instr_word,
  input  logic [XLEN-1:0]      rs_val,
  input  logic [XLEN-1:0]      rt_val,
  input  logic                 sync_ack,
  output logic                 exc_req,
  output logic [CAUSE_W-1:0]   exc_cause,
  output logic                 barrier_req,
  output logic                 illegal_funct
);

  dec_t              dec;
  logic [N_TRAP-1:0] cond;
  logic              trap_hit;
  logic              exc_fire;
  cause_e            cause_d;

  spec_decode u_dec (
    .valid (instr_valid),
    .instr (instr_word),
    .dec   (dec)
  );

  trap_compare #(.W(XLEN), .SHARED_SUB(SHARED_SUB)) u_cmp (
    .a    (rs_val),
    .b    (rt_val),
    .cond (cond)
  );

  assign trap_hit = |(dec.trap_sel & cond);
  assign exc_fire = dec.sys | dec.brk | trap_hit;

  always_comb begin
    cause_d = CAUSE_NONE;
    if (dec.sys)       cause_d = CAUSE_SYS;
    else if (dec.brk)  cause_d = CAUSE_BRK;
    else if (trap_hit) cause_d = CAUSE_TRAP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_req       <= 1'b0;
      exc_cause     <= CAUSE_NONE;
      illegal_funct <= 1'b0;
    end else begin
      exc_req       <= exc_fire;
      exc_cause     <= cause_d;
      illegal_funct <= dec.illegal;
    end
  end

  barrier_ctrl u_bar (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (dec.sync),
    .ack   (sync_ack),
    .req   (barrier_req)
  );

endmodule

// File: rtl/spec_exc_chk.sv
module spec_exc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       instr_valid,
  input logic       sync_ack,
  input logic       exc_req,
  input logic [1:0] exc_cause,
  input logic       barrier_req,
  input logic       illegal_funct,
  input logic       trap_hit
);

  a_r11_idle_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req |-> exc_cause == 2'b00);

  a_r10_no_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> !exc_req && !illegal_funct);

  a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    barrier_req && !sync_ack |=> barrier_req);

  a_r4_rise_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(barrier_req) |-> $past(instr_valid));

  a_r9_illegal_excl: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_funct |-> !exc_req);

  a_r5_trap_fires: assert property (@(posedge clk) disable iff (!rst_n)
    trap_hit |=> exc_req && exc_cause == 2'b11);

endmodule

bind spec_exc_unit spec_exc_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .instr_valid   (instr_valid),
  .sync_ack      (sync_ack),
  .exc_req       (exc_req),
  .exc_cause     (exc_cause),
  .barrier_req   (barrier_req),
  .illegal_funct (illegal_funct),
  .trap_hit      (trap_hit)
);

// File: tb/sim_spec_exc_unit.sv
module sim_spec_exc_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic        sync_ack = 1'b0;
  logic        exc_req;
  logic [1:0]  exc_cause;
  logic        barrier_req;
  logic        illegal_funct;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spec_exc_unit u0 (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .rs_val(rs_val), .rt_val(rt_val), .sync_ack(sync_ack), .exc_req(exc_req),
    .exc_cause(exc_cause), .barrier_req(barrier_req), .illegal_funct(illegal_funct)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit trap_expected(input logic [5:0] fn, input logic [31:0] a,
                                       input logic [31:0] b);
    case (fn)
      6'h30: return $signed(a) >= $signed(b);
      6'h31: return a >= b;
      6'h32: return $signed(a) < $signed(b);
      6'h33: return a < b;
      6'h34: return a == b;
      6'h36: return a != b;
      default: return 1'b0;
    endcase
  endfunction

  // one instruction, one result cycle, then the pulse must be gone
  task automatic run_instr(input string req, input logic vld, input logic [5:0] opc,
                           input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
    bit       is_sp, is_trap, hit, ill;
    logic [1:0] cause;
    is_sp   = vld && (opc == 6'd0);
    is_trap = fn inside {6'h30, 6'h31, 6'h32, 6'h33, 6'h34, 6'h36};
    hit     = is_sp && is_trap && trap_expected(fn, a, b);
    ill     = is_sp && !is_trap && !(fn inside {6'h0C, 6'h0D, 6'h0F});
    cause   = !is_sp ? 2'b00 : (fn == 6'h0C) ? 2'b01 : (fn == 6'h0D) ? 2'b10 :
              hit ? 2'b11 : 2'b00;
    @(negedge clk);
    instr_valid = vld;
    instr_word  = {opc, 5'd3, 5'd7, 5'd9, 5'd0, fn};
    rs_val = a; rt_val = b;
    @(negedge clk);
    instr_valid = 1'b0;
    check({req, " exc_req"}, 32'(exc_req), 32'(cause != 2'b00));
    check({req, " exc_cause"}, 32'(exc_cause), 32'(cause));
    check({req, " illegal_funct"}, 32'(illegal_funct), 32'(ill));
    check({req, " barrier_req"}, 32'(barrier_req), 32'd0);
    @(negedge clk);
    check({req, " pulse end"}, 32'(exc_req), 32'd0);
    check({req, " illegal end"}, 32'(illegal_funct), 32'd0);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check("R1 exc_req", 32'(exc_req), 0);
    check("R1 barrier_req", 32'(barrier_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {29'd0, exc_req, barrier_req, illegal_funct}, 0);
    check("R1 cause", 32'(exc_cause), 0);
  endtask

  task automatic test_sync();
    @(negedge clk);
    instr_valid = 1'b1;
    instr_word  = {6'd0, 20'd0, 6'h0F};
    @(negedge clk);
    instr_valid = 1'b0;
    check("R4 set", 32'(barrier_req), 1);
    check("R4 no exc", 32'(exc_req), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R4 hold", 32'(barrier_req), 1);
    end
    sync_ack = 1'b1;
    @(negedge clk);
    sync_ack = 1'b0;
    check("R4 clear", 32'(barrier_req), 0);
    @(negedge clk);
    check("R4 stays clear", 32'(barrier_req), 0);
  endtask

  task automatic test_signed();
    run_instr("R5 tge -1>=1", 1, 0, 6'h30, 32'hFFFF_FFFF, 32'd1);
    run_instr("R5 tge 5>=5", 1, 0, 6'h30, 32'd5, 32'd5);
    run_instr("R5 tge 1>=-1", 1, 0, 6'h30, 32'd1, 32'hFFFF_FFFF);
    run_instr("R5 tlt min<max", 1, 0, 6'h32, 32'h8000_0000, 32'h7FFF_FFFF);
    run_instr("R5 tlt max<min", 1, 0, 6'h32, 32'h7FFF_FFFF, 32'h8000_0000);
  endtask

  task automatic test_unsigned();
    run_instr("R6 tgeu big>=1", 1, 0, 6'h31, 32'hFFFF_FFFF, 32'd1);
    run_instr("R6 tgeu 1>=big", 1, 0, 6'h31, 32'd1, 32'hFFFF_FFFF);
    run_instr("R6 tltu 1<big", 1, 0, 6'h33, 32'd1, 32'hFFFF_FFFF);
    run_instr("R6 tltu eq", 1, 0, 6'h33, 32'd9, 32'd9);
  endtask

  task automatic test_equality();
    run_instr("R7 teq eq", 1, 0, 6'h34, 32'hA5A5_0001, 32'hA5A5_0001);
    run_instr("R7 teq ne", 1, 0, 6'h34, 32'hA5A5_0001, 32'hA5A5_0002);
    run_instr("R7 tne ne", 1, 0, 6'h36, 32'd0, 32'h8000_0000);
    run_instr("R8 tne eq false", 1, 0, 6'h36, 32'd4, 32'd4);
  endtask

  initial begin
    test_reset();
    run_instr("R2 syscall", 1, 0, 6'h0C, 32'd0, 32'd0);
    run_instr("R3 break", 1, 0, 6'h0D, 32'd1, 32'd2);
    test_sync();
    test_signed();
    test_unsigned();
    test_equality();
    run_instr("R9 illegal 0x20", 1, 0, 6'h20, 32'd0, 32'd0);
    run_instr("R9 illegal 0x35", 1, 0, 6'h35, 32'd3, 32'd3);
    run_instr("R10 invalid", 0, 0, 6'h0C, 32'd0, 32'd0);
    run_instr("R10 nonzero opcode", 1, 6'h08, 6'h0D, 32'd0, 32'd0);
    run_instr("R11 cause after", 1, 0, 6'h37, 32'd0, 32'd0);
    check("R11 idle cause", 32'(exc_cause), 0);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R10 watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule